// File: doc/BRIEF.md
# Locked Sample Register Bank

This block is the register file of a three-axis field sensor. It holds the six result bytes (X, Z and Y, high byte first), the two temperature bytes, two configuration registers, a mode register, a status register and three fixed identification bytes. A bus slave drives it with a pointer load and with per-byte read and write strobes. Each byte access moves an internal pointer. The measurement sequencer posts finished results and receives the operating-mode code back.

The bank keeps a result set coherent. Once a host starts to read the result bytes, the bank refuses new results until the whole set has been read and the next measurement begins. A refused result, or a result that replaces one nobody read, is flagged. The ready flag drops when a measurement starts and stays low for a minimum time. It is also driven out inverted on an active-low pin. In single-shot mode the bank puts the mode field into idle by itself once a result is stored.

Top module: `magreg_bank`

## Requirements
- R1: Register addresses: 0x00 config A, 0x01 config B, 0x02 mode, 0x03..0x08 result bytes (X high, X low, Z high, Z low, Y high, Y low), 0x09 status, 0x0A..0x0C identification 0x48, 0x34, 0x33, 0x31/0x32 temperature high/low. Reads of any other address return 0x00.
- R2: After reset, config A reads 0x10, config B reads 0x20, mode reads 0x01, and the result, temperature and status bytes read 0x00.
- R3: The lock flag sets when a result-byte read leaves some, but not all, of the six bytes read since the last store. It also sets when the mode register is read.
- R4: While locked, a posted result changes neither the result bytes nor the temperature bytes. A result posted in the same cycle as a lock-setting read is refused, and that read returns the old byte.
- R5: The lock clears when a measurement starts after all six bytes have been read, when the mode register is written, and when config A is written.
- R6: The overrun flag sets when a result is refused, or when a result arrives while the previous stored set has had none of its bytes read. It clears on a result-byte read. A set in the same cycle as a clear wins.
- R7: Ready clears on a measurement start. It sets when a result is stored, but no sooner than HOLD_US microseconds (HOLD_US*CLK_HZ/1e6 clock cycles) after it last cleared. A result stored during that window raises ready in exactly the first cycle the window allows.
- R8: `drdy_n` is always the inverse of ready.
- R9: The status register holds ready in bit 0, lock in bit 1 and overrun in bit 2. Its other bits are zero.
- R10: The pointer takes the loaded value. It then advances by one after each byte read or write, except that from 0x08 it goes to 0x03.
- R11: `mode_md` shows mode bits [1:0] (00 continuous, 01 single, 10/11 idle). When a result is stored while the code is 01, the code becomes 11.
- R12: Config B bits [4:0] and mode bits 6 and 3 ignore writes and read 0. Writes to status, result, identification, temperature or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_start | input | 1 | Sequencer begins a measurement |
| meas_done | input | 1 | One-cycle strobe: result on meas_* is valid |
| meas_x | input | 16 | X axis result |
| meas_z | input | 16 | Z axis result |
| meas_y | input | 16 | Y axis result |
| meas_temp | input | 16 | Temperature result |
| bus_ptr_set | input | 1 | Load the register pointer |
| bus_ptr_val | input | 8 | Pointer value to load |
| bus_rd | input | 1 | Byte read at the pointer completes |
| bus_wr | input | 1 | Byte write at the pointer |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Register at the current pointer |
| stat_rdy | output | 1 | Ready flag |
| stat_lock | output | 1 | Lock flag |
| stat_dow | output | 1 | Overrun flag |
| drdy_n | output | 1 | Active-low data-ready pin |
| mode_md | output | 2 | Operating-mode code to the sequencer |

## Verification
A result strobe and a host read of the first result byte can land in the same cycle. The bench drives both strobes on one clock edge. It checks that the byte returned is the old one, that lock and overrun are both set afterwards, and that the next byte read still belongs to the old set. A second collision is between a store and the ready hold window: the bench starts a measurement, posts the result on the following cycle, and samples ready one cycle before and exactly at the window's end.

// File: rtl/magreg_pkg.sv
package magreg_pkg;

    localparam int BYTE_W     = 8;
    localparam int AXIS_W     = 16;
    localparam int DATA_BYTES = 6;

    localparam logic [7:0] A_CFGA       = 8'h00;
    localparam logic [7:0] A_CFGB       = 8'h01;
    localparam logic [7:0] A_MODE       = 8'h02;
    localparam logic [7:0] A_DATA_FIRST = 8'h03;
    localparam logic [7:0] A_DATA_LAST  = 8'h08;
    localparam logic [7:0] A_STATUS     = 8'h09;
    localparam logic [7:0] A_ID0        = 8'h0A;
    localparam logic [7:0] A_ID1        = 8'h0B;
    localparam logic [7:0] A_ID2        = 8'h0C;
    localparam logic [7:0] A_TEMP_HI    = 8'h31;
    localparam logic [7:0] A_TEMP_LO    = 8'h32;

    localparam logic [7:0] ID0_VAL = 8'h48;
    localparam logic [7:0] ID1_VAL = 8'h34;
    localparam logic [7:0] ID2_VAL = 8'h33;

    localparam logic [7:0] RST_CFGA = 8'h10;
    localparam logic [7:0] RST_CFGB = 8'h20;
    localparam logic [7:0] RST_MODE = 8'h01;

    localparam logic [7:0] KEEP_CFGB = 8'hE0;
    localparam logic [7:0] KEEP_MODE = 8'hB7;

    localparam int ST_RDY  = 0;
    localparam int ST_LOCK = 1;
    localparam int ST_DOW  = 2;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_SINGLE = 2'b01,
        MD_IDLE_A = 2'b10,
        MD_IDLE   = 2'b11
    } md_e;

    typedef struct packed {
        logic [AXIS_W-1:0] x;
        logic [AXIS_W-1:0] z;
        logic [AXIS_W-1:0] y;
        logic [AXIS_W-1:0] t;
    } meas_t;

    function automatic logic [BYTE_W-1:0] axis_byte(input meas_t m, input int idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            0:       b = m.x[15:8];
            1:       b = m.x[7:0];
            2:       b = m.z[15:8];
            3:       b = m.z[7:0];
            4:       b = m.y[15:8];
            5:       b = m.y[7:0];
            default: b = '0;
        endcase
        return b;
    endfunction

    function automatic logic is_data_addr(input logic [7:0] a);
        return (a >= A_DATA_FIRST) && (a <= A_DATA_LAST);
    endfunction

endpackage

// File: rtl/magreg_ptr.sv
module magreg_ptr
    import magreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_en,
    input  logic [7:0] set_val,
    input  logic       step,
    output logic [7:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (set_en)
            ptr <= set_val;
        else if (step)
            ptr <= (ptr == A_DATA_LAST) ? A_DATA_FIRST : ptr + 8'd1;
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !set_en && ptr == A_DATA_LAST) |=> (ptr == A_DATA_FIRST)); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !set_en && ptr != A_DATA_LAST) |=> (ptr == $past(ptr) + 8'd1)); // R10

endmodule

// File: rtl/magreg_ctrl.sv
module magreg_ctrl
    import magreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       stored,
    output logic [7:0] cfg_a,
    output logic [7:0] cfg_b,
    output logic [7:0] mode
);

    logic wr_a, wr_b, wr_m;
    md_e  md_now;

    always_comb begin
        wr_a   = wr_en && (addr == A_CFGA);
        wr_b   = wr_en && (addr == A_CFGB);
        wr_m   = wr_en && (addr == A_MODE);
        md_now = md_e'(mode[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a <= RST_CFGA;
            cfg_b <= RST_CFGB;
            mode  <= RST_MODE;
        end else begin
            if (wr_a)
                cfg_a <= wdata;
            if (wr_b)
                cfg_b <= wdata & KEEP_CFGB;
            if (wr_m)
                mode <= wdata & KEEP_MODE;
            else if (stored && md_now == MD_SINGLE)
                mode[1:0] <= MD_IDLE;
        end
    end

    AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (stored && !wr_m && mode[1:0] == MD_SINGLE) |=> (mode[1:0] == MD_IDLE)); // R11

    AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((cfg_b & ~KEEP_CFGB) == 8'h00) && ((mode & ~KEEP_MODE) == 8'h00)); // R12

endmodule

// File: rtl/magreg_hold.sv
module magreg_hold #(
    parameter int TICK_DIV = 50,
    parameter int HOLD_US  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic release_ok
);

    localparam int PRE_W = $clog2(TICK_DIV + 1);
    localparam int US_W  = $clog2(HOLD_US + 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             last_tick, hold_end;

    always_comb begin
        last_tick  = (pre_q == PRE_W'(TICK_DIV - 1));
        hold_end   = busy && last_tick && (us_q == US_W'(HOLD_US - 1));
        release_ok = !busy || hold_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pre_q <= '0;
            us_q  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            pre_q <= '0;
            us_q  <= '0;
        end else if (busy) begin
            if (last_tick) begin
                pre_q <= '0;
                if (hold_end)
                    busy <= 1'b0;
                else
                    us_q <= us_q + US_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    AST_HOLD_ARMED: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R7

    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (us_q < US_W'(HOLD_US))); // R7

endmodule

// File: rtl/magreg_sample.sv
module magreg_sample
    import magreg_pkg::*;
#(
    parameter int HOLD_CYC = 10000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              meas_start,
    input  logic                              meas_done,
    input  meas_t                             meas_in,
    input  logic                              rd_en,
    input  logic                              wr_en,
    input  logic [7:0]                        addr,
    input  logic                              release_ok,
    output logic [DATA_BYTES-1:0][BYTE_W-1:0] data_bytes,
    output logic [AXIS_W-1:0]                 temp_q,
    output logic                              rdy_q,
    output logic                              lock_q,
    output logic                              dow_q,
    output logic                              stored
);

    localparam logic [DATA_BYTES-1:0] ALL_READ = '1;
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [DATA_BYTES-1:0] mask_q, rd_bit, mask_upd;
    logic                  unread_q, pend_q;
    logic                  data_rd, lock_set, lock_clr, lock_nx, load, dow_set;
    logic [2:0]            idx;

    always_comb begin
        idx      = 3'(addr - A_DATA_FIRST);
        data_rd  = rd_en && is_data_addr(addr);
        rd_bit   = data_rd ? (DATA_BYTES'(1) << idx) : '0;
        mask_upd = mask_q | rd_bit;
        lock_set = (data_rd && mask_upd != ALL_READ) || (rd_en && addr == A_MODE);
        lock_clr = (meas_start && mask_q == ALL_READ)
                 || (wr_en && (addr == A_MODE || addr == A_CFGA));
        lock_nx  = lock_set || (lock_q && !lock_clr);
        load     = meas_done && !lock_nx;
        dow_set  = meas_done && (lock_nx || unread_q);
        stored   = load;
    end

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_byte
        logic [BYTE_W-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst)
                b_q <= '0;
            else if (load)
                b_q <= axis_byte(meas_in, i);
        end
        assign data_bytes[i] = b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q   <= '0;
            mask_q   <= '0;
            lock_q   <= 1'b0;
            unread_q <= 1'b0;
            dow_q    <= 1'b0;
            rdy_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            lock_q <= lock_nx;
            mask_q <= load ? '0 : mask_upd;
            if (load)
                temp_q <= meas_in.t;
            if (load)
                unread_q <= 1'b1;
            else if (data_rd)
                unread_q <= 1'b0;
            if (dow_set)
                dow_q <= 1'b1;
            else if (data_rd)
                dow_q <= 1'b0;
            if (meas_start) begin
                rdy_q  <= 1'b0;
                pend_q <= load;
            end else if ((load || pend_q) && release_ok) begin
                rdy_q  <= 1'b1;
                pend_q <= 1'b0;
            end else if (load) begin
                pend_q <= 1'b1;
            end
        end
    end

    logic [CNT_W-1:0] low_cnt;
    logic             timed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            timed_q <= 1'b0;
        end else if (rdy_q) begin
            low_cnt <= '0;
            timed_q <= 1'b1;
        end else if (low_cnt != CNT_W'(HOLD_CYC)) begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    AST_RDY_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(rdy_q) && timed_q) |-> (low_cnt >= CNT_W'(HOLD_CYC))); // R7

    AST_HOLD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !lock_clr) |=> ($stable(data_bytes) && $stable(temp_q))); // R4

    AST_DOW_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (meas_done && lock_q && !lock_clr) |=> dow_q); // R6

    AST_LOCK_ON_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !load && mask_upd != ALL_READ) |=> lock_q); // R3

endmodule

// File: rtl/magreg_bank.sv
module magreg_bank
    import magreg_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int HOLD_US = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        meas_start,
    input  logic        meas_done,
    input  logic [15:0] meas_x,
    input  logic [15:0] meas_z,
    input  logic [15:0] meas_y,
    input  logic [15:0] meas_temp,
    input  logic        bus_ptr_set,
    input  logic [7:0]  bus_ptr_val,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  rd_data,
    output logic        stat_rdy,
    output logic        stat_lock,
    output logic        stat_dow,
    output logic        drdy_n,
    output logic [1:0]  mode_md
);

    localparam int TICK_DIV = CLK_HZ / 1_000_000;
    localparam int HOLD_CYC = TICK_DIV * HOLD_US;

    logic [7:0]                        ptr, cfg_a, cfg_b, mode, status;
    logic [DATA_BYTES-1:0][BYTE_W-1:0] data_bytes;
    logic [AXIS_W-1:0]                 temp_q;
    logic                              stored, hold_busy, release_ok;
    logic [2:0]                        ridx;
    meas_t                             meas_in;

    assign meas_in = '{x: meas_x, z: meas_z, y: meas_y, t: meas_temp};

    magreg_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .set_en  (bus_ptr_set),
        .set_val (bus_ptr_val),
        .step    (bus_rd || bus_wr),
        .ptr     (ptr)
    );

    magreg_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (ptr),
        .wdata  (bus_wdata),
        .stored (stored),
        .cfg_a  (cfg_a),
        .cfg_b  (cfg_b),
        .mode   (mode)
    );

    magreg_hold #(
        .TICK_DIV (TICK_DIV),
        .HOLD_US  (HOLD_US)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .start      (meas_start),
        .busy       (hold_busy),
        .release_ok (release_ok)
    );

    magreg_sample #(
        .HOLD_CYC (HOLD_CYC)
    ) u_sample (
        .clk        (clk),
        .rst        (rst),
        .meas_start (meas_start),
        .meas_done  (meas_done),
        .meas_in    (meas_in),
        .rd_en      (bus_rd),
        .wr_en      (bus_wr),
        .addr       (ptr),
        .release_ok (release_ok),
        .data_bytes (data_bytes),
        .temp_q     (temp_q),
        .rdy_q      (stat_rdy),
        .lock_q     (stat_lock),
        .dow_q      (stat_dow),
        .stored     (stored)
    );

    always_comb begin
        status          = '0;
        status[ST_RDY]  = stat_rdy;
        status[ST_LOCK] = stat_lock;
        status[ST_DOW]  = stat_dow;
        ridx            = 3'(ptr - A_DATA_FIRST);
        if (is_data_addr(ptr)) begin
            rd_data = data_bytes[ridx];
        end else begin
            case (ptr)
                A_CFGA:    rd_data = cfg_a;
                A_CFGB:    rd_data = cfg_b;
                A_MODE:    rd_data = mode;
                A_STATUS:  rd_data = status;
                A_ID0:     rd_data = ID0_VAL;
                A_ID1:     rd_data = ID1_VAL;
                A_ID2:     rd_data = ID2_VAL;
                A_TEMP_HI: rd_data = temp_q[15:8];
                A_TEMP_LO: rd_data = temp_q[7:0];
                default:   rd_data = 8'h00;
            endcase
        end
        drdy_n  = ~stat_rdy;
        mode_md = mode[1:0];
    end

    AST_HOLD_GATES_RDY: assert property (@(posedge clk) disable iff (rst)
        (hold_busy && !release_ok && !stat_rdy) |=> !stat_rdy); // R7

endmodule

// File: tb/tb_magreg_bank.sv
module tb_magreg_bank;

    localparam int HOLD_US_TB = 4;
    localparam int NCYC       = HOLD_US_TB * 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meas_start = 1'b0, meas_done = 1'b0;
    logic [15:0] meas_x = '0, meas_z = '0, meas_y = '0, meas_temp = '0;
    logic        bus_ptr_set = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_ptr_val = '0, bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        stat_rdy, stat_lock, stat_dow, drdy_n;
    logic [1:0]  mode_md;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    magreg_bank #(.CLK_HZ(50_000_000), .HOLD_US(HOLD_US_TB)) dut (
        .clk(clk), .rst(rst), .meas_start(meas_start), .meas_done(meas_done),
        .meas_x(meas_x), .meas_z(meas_z), .meas_y(meas_y), .meas_temp(meas_temp),
        .bus_ptr_set(bus_ptr_set), .bus_ptr_val(bus_ptr_val), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .stat_rdy(stat_rdy), .stat_lock(stat_lock), .stat_dow(stat_dow),
        .drdy_n(drdy_n), .mode_md(mode_md)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        bus_ptr_set = 1'b1; bus_ptr_val = a;
        @(negedge clk);
        bus_ptr_set = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        v = rd_data; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic start_meas();
        meas_start = 1'b1;
        @(negedge clk);
        meas_start = 1'b0;
    endtask

    task automatic post(input logic [15:0] x, z, y, t);
        meas_x = x; meas_z = z; meas_y = y; meas_temp = t; meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic [15:0] x, z, y, input int i);
        logic [15:0] w;
        w = (i < 2) ? x : (i < 4) ? z : y;
        return (i % 2 == 0) ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [7:0] stat_of(input logic r, l, d);
        return {5'b0, d, l, r};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] lx, lz, ly, lt;
        logic [15:0] rx, rz, ry;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk("R2", "rdy", 16'(stat_rdy), 16'h0);
        chk("R2", "lock", 16'(stat_lock), 16'h0);
        chk("R2", "dow", 16'(stat_dow), 16'h0);
        chk("R8", "drdy_n reset", 16'(drdy_n), 16'h1);
        chk("R11", "md reset", 16'(mode_md), 16'h1);
        set_ptr(8'h0A);
        rd(v); chk("R1", "id0", 16'(v), 16'h48);
        rd(v); chk("R10", "id1 after step", 16'(v), 16'h34);
        rd(v); chk("R1", "id2", 16'(v), 16'h33);
        set_ptr(8'h00);
        rd(v); chk("R2", "cfg a", 16'(v), 16'h10);
        rd(v); chk("R2", "cfg b", 16'(v), 16'h20);
        chk("R3", "lock before mode read", 16'(stat_lock), 16'h0);
        rd(v); chk("R2", "mode", 16'(v), 16'h01);
        chk("R3", "lock after mode read", 16'(stat_lock), 16'h1);
        set_ptr(8'h31);
        rd(v); chk("R2", "temp hi reset", 16'(v), 16'h0);
        set_ptr(8'h20);
        rd(v); chk("R1", "unmapped", 16'(v), 16'h0);
        set_ptr(8'h02);
        wr(8'h00);
        chk("R5", "lock cleared by mode write", 16'(stat_lock), 16'h0);
        chk("R11", "md continuous", 16'(mode_md), 16'h0);

        // sweep of results with ready timing and full readout
        for (int k = 0; k < 6; k++) begin
            lx = 16'(k * 613 + 100);
            lz = 16'(16'hF800 + k * 301);
            ly = 16'(k * 97 - 50);
            lt = 16'(k * 11 + 7);
            start_meas();
            chk("R5", "lock after start", 16'(stat_lock), 16'h0);
            chk("R7", "rdy cleared by start", 16'(stat_rdy), 16'h0);
            post(lx, lz, ly, lt);
            repeat (NCYC - 2) @(negedge clk);
            chk("R7", "rdy still held", 16'(stat_rdy), 16'h0);
            chk("R8", "drdy_n held", 16'(drdy_n), 16'h1);
            @(negedge clk);
            chk("R7", "rdy at window end", 16'(stat_rdy), 16'h1);
            chk("R8", "drdy_n active", 16'(drdy_n), 16'h0);
            set_ptr(8'h03);
            for (int i = 0; i < 6; i++) begin
                rd(v);
                chk("R1", $sformatf("data byte %0d", i), 16'(v), 16'(exp_byte(lx, lz, ly, i)));
                if (i == 0) chk("R3", "lock after first byte", 16'(stat_lock), 16'h1);
            end
            rd(v); chk("R10", "wrap to x high", 16'(v), 16'(lx[15:8]));
            set_ptr(8'h31);
            rd(v); chk("R1", "temp hi", 16'(v), 16'(lt[15:8]));
            rd(v); chk("R1", "temp lo", 16'(v), 16'(lt[7:0]));
        end

        set_ptr(8'h09);
        rd(v); chk("R9", "status rdy+lock", 16'(v), 16'(stat_of(1'b1, 1'b1, 1'b0)));

        // refused result while locked
        post(16'h0123, 16'h0456, 16'h0789, 16'h0AAA);
        chk("R6", "dow on refusal", 16'(stat_dow), 16'h1);
        set_ptr(8'h09);
        rd(v); chk("R9", "status with dow", 16'(v), 16'(stat_of(1'b1, 1'b1, 1'b1)));
        set_ptr(8'h03);
        rd(v); chk("R4", "old x high kept", 16'(v), 16'(lx[15:8]));
        chk("R6", "dow cleared by data read", 16'(stat_dow), 16'h0);
        set_ptr(8'h31);
        rd(v); chk("R4", "old temp kept", 16'(v), 16'(lt[15:8]));

        // start after full read, pending store, then unread overwrite
        start_meas();
        chk("R5", "lock cleared by start", 16'(stat_lock), 16'h0);
        post(16'h0111, 16'h0222, 16'h0333, 16'h0044);
        repeat (NCYC) @(negedge clk);
        chk("R7", "pending rdy released", 16'(stat_rdy), 16'h1);
        post(16'h0555, 16'h0666, 16'h0777, 16'h0088);
        chk("R6", "dow on unread overwrite", 16'(stat_dow), 16'h1);
        chk("R4", "unlocked store keeps rdy", 16'(stat_rdy), 16'h1);
        set_ptr(8'h03);
        rd(v); chk("R6", "overwrite data", 16'(v), 16'h05);
        rd(v); chk("R6", "overwrite data lo", 16'(v), 16'h55);
        chk("R3", "partial lock", 16'(stat_lock), 16'h1);

        // config A write clears lock
        set_ptr(8'h00);
        wr(8'h70);
        chk("R5", "lock cleared by cfg a write", 16'(stat_lock), 16'h0);
        set_ptr(8'h00);
        rd(v); chk("R1", "cfg a readback", 16'(v), 16'h70);

        // collision: result strobe with first data read
        rx = 16'h0A1B; rz = 16'h0C2D; ry = 16'h0E3F;
        post(rx, rz, ry, 16'h0011);
        chk("R4", "store while unlocked", 16'(stat_lock), 16'h0);
        set_ptr(8'h03);
        v = rd_data;
        bus_rd = 1'b1;
        meas_x = 16'h7777; meas_z = 16'h6666; meas_y = 16'h5555; meas_temp = 16'h4444;
        meas_done = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; meas_done = 1'b0;
        chk("R4", "collision read old", 16'(v), 16'(rx[15:8]));
        chk("R3", "collision lock", 16'(stat_lock), 16'h1);
        chk("R6", "collision dow set wins", 16'(stat_dow), 16'h1);
        rd(v); chk("R4", "collision next byte old", 16'(v), 16'(rx[7:0]));
        chk("R6", "dow cleared later", 16'(stat_dow), 16'h0);

        // reserved bits and ignored writes
        set_ptr(8'h02);
        wr(8'hFF);
        chk("R5", "lock cleared by mode write", 16'(stat_lock), 16'h0);
        chk("R11", "md idle code", 16'(mode_md), 16'h3);
        set_ptr(8'h02);
        rd(v); chk("R12", "mode reserved", 16'(v), 16'hB7);
        chk("R3", "lock by mode read", 16'(stat_lock), 16'h1);
        set_ptr(8'h01);
        wr(8'hFF);
        set_ptr(8'h01);
        rd(v); chk("R12", "cfg b reserved", 16'(v), 16'hE0);
        set_ptr(8'h09);
        wr(8'hFF);
        set_ptr(8'h09);
        rd(v); chk("R12", "status write ignored", 16'(v), 16'(stat_of(1'b1, 1'b1, 1'b0)));
        set_ptr(8'h03);
        wr(8'h55);
        set_ptr(8'h03);
        rd(v); chk("R12", "data write ignored", 16'(v), 16'(rx[15:8]));
        set_ptr(8'h0A);
        wr(8'h00);
        set_ptr(8'h0A);
        rd(v); chk("R12", "id write ignored", 16'(v), 16'h48);

        // single-shot returns to idle
        set_ptr(8'h02);
        wr(8'h01);
        chk("R11", "md single", 16'(mode_md), 16'h1);
        chk("R5", "lock cleared", 16'(stat_lock), 16'h0);
        start_meas();
        post(16'h0321, 16'h0432, 16'h0543, 16'h0099);
        chk("R11", "md idle after store", 16'(mode_md), 16'h3);
        chk("R7", "rdy held after single", 16'(stat_rdy), 16'h0);
        repeat (NCYC) @(negedge clk);
        chk("R7", "rdy after window", 16'(stat_rdy), 16'h1);
        set_ptr(8'h02);
        rd(v); chk("R11", "mode reg idle", 16'(v), 16'h03);
        set_ptr(8'h08);
        rd(v); chk("R1", "y low", 16'(v), 16'h43);
        rd(v); chk("R10", "wrap from 0x08", 16'(v), 16'h03);

        finish_run();
    end

endmodule